// File: doc/BRIEF.md
# SONET Path Parity Byte Generator and Checker

This block produces and verifies the path-level bit-interleaved parity byte of a SONET synchronous payload envelope. It has two independent directions. Each direction sees a byte stream with two strobes. One strobe marks bytes that belong to the payload envelope. The other marks the parity-byte position of each frame.

In the transmit direction, the block XORs every payload byte of one frame into an 8-lane accumulator. It then writes the result into the parity slot of the next frame. All other bytes pass through one register stage unchanged. A disable input replaces the inserted value with 0x00.

In the receive direction, the block builds the same accumulation from the incoming bytes. At each parity slot it compares the accumulation with the received byte and counts every differing bit as one error. The count saturates. A read strobe copies the count into a snapshot register and restarts the counter in the same cycle, without losing that cycle's errors.

Each direction runs a small window tracker with two states. SEEK is the state after reset, before any parity slot has been seen. TRACK is entered on the first parity slot and held until reset. The transitions are SEEK -> TRACK on a parity slot, and TRACK -> TRACK otherwise. Only a window that started at a parity slot, and so is complete, is inserted or compared.

Top module: `path_bip8_unit`

## Requirements
- R1: While reset is asserted and just after it, `tx_data_out`, `err_count` and `count_snap` are all zero.
- R2: A transmit cycle without `tx_b3_slot` shows `tx_data_in` on `tx_data_out` one clock later.
- R3: The parity window is the set of bytes with the valid strobe high that lie strictly between two consecutive parity slots. The slot byte itself is excluded. Bit n of the parity is the XOR of bit n of every byte in the window (even parity). Once in TRACK, a transmit slot outputs that parity one clock later.
- R4: The first parity slot after reset moves the tracker from SEEK to TRACK. At that slot the transmit output is 0x00 and no receive comparison is made.
- R5: When `tx_gen_disable` is 1 during a transmit slot, the output for that slot is 0x00. Accumulation still continues, so the next slot carries a correct parity.
- R6: At each receive slot in TRACK, `err_count` rises by the number of set bits in (`rx_data` XOR computed parity), from 0 to 8, visible one clock later.
- R7: `err_count` saturates at 2^CNT_W-1 and does not wrap.
- R8: A cycle with `cnt_read` high loads `count_snap` with the count from before that cycle. The counter restarts at that cycle's mismatch count, so no error is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_spe_valid | input | 1 | Transmit byte belongs to the payload envelope |
| tx_b3_slot | input | 1 | Transmit byte is the parity slot |
| tx_data_in | input | BYTE_W | Transmit byte before scrambling |
| tx_gen_disable | input | 1 | 1 forces 0x00 into the parity slot |
| tx_data_out | output | BYTE_W | Transmit byte with the parity inserted |
| rx_spe_valid | input | 1 | Receive byte belongs to the payload envelope |
| rx_b3_slot | input | 1 | Receive byte is the parity slot |
| rx_data | input | BYTE_W | Receive byte after descrambling |
| cnt_read | input | 1 | Snapshot the count and restart the counter |
| err_count | output | CNT_W | Live saturating bit-error count |
| count_snap | output | CNT_W | Count captured by the last read |

## Verification
Every result appears exactly one clock after the input cycle that causes it. This holds for the transmit output byte, the count update and the snapshot. The driver applies each cycle's inputs on the falling edge and pushes the expected transmit byte into a queue. A monitor wakes just after each rising edge and pops one entry per cycle, so the expected and actual bytes stay aligned by construction. The count and snapshot are checked at the same point after the edge that closes the step.

// File: rtl/bip8_pkg.sv
package bip8_pkg;
    typedef enum logic {
        WIN_SEEK  = 1'b0,
        WIN_TRACK = 1'b1
    } win_state_e;
endpackage

// File: rtl/bip_window_track.sv
module bip_window_track
    import bip8_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spe_valid,
    input  logic              b3_slot,
    input  logic [BYTE_W-1:0] data,
    output logic [BYTE_W-1:0] parity,
    output logic              tracking
);
    win_state_e state_q, state_d;
    logic [BYTE_W-1:0] acc_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_SEEK;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        tracking = 1'b0;
        unique case (state_q)
            WIN_SEEK: begin
                if (b3_slot) state_d = WIN_TRACK;
            end
            WIN_TRACK: begin
                tracking = 1'b1;
            end
            default: state_d = WIN_SEEK;
        endcase
    end

    // lane accumulator: slot closes the window, payload bytes fold in
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (b3_slot)   acc_q <= '0;
        else if (spe_valid) acc_q <= acc_q ^ data;
    end

    assign parity = acc_q;
endmodule

// File: rtl/bip_popcount.sv
module bip_popcount #(
    parameter int BYTE_W = 8,
    localparam int PC_W  = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] bits,
    output logic [PC_W-1:0]   ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            ones = ones + PC_W'(bits[i]);
        end
    end
endmodule

// File: rtl/bip_err_counter.sv
module bip_err_counter #(
    parameter int CNT_W = 16,
    parameter int PC_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  add,
    input  logic             rd,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap
);
    localparam int SUM_W = CNT_W + PC_W;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

    function automatic logic [CNT_W-1:0] sat(input logic [SUM_W-1:0] v);
        return (v > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : v[CNT_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            snap  <= '0;
        end else if (rd) begin
            snap  <= count;
            count <= sat(SUM_W'(add));
        end else begin
            count <= sat(SUM_W'(count) + SUM_W'(add));
        end
    end
endmodule

// File: rtl/path_bip8_unit.sv
module path_bip8_unit #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_spe_valid,
    input  logic              tx_b3_slot,
    input  logic [BYTE_W-1:0] tx_data_in,
    input  logic              tx_gen_disable,
    output logic [BYTE_W-1:0] tx_data_out,
    input  logic              rx_spe_valid,
    input  logic              rx_b3_slot,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              cnt_read,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  count_snap
);
    localparam int PC_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] tx_par, rx_par;
    logic              tx_track, rx_track;
    logic [PC_W-1:0]   rx_ones, rx_add;

    bip_window_track #(.BYTE_W(BYTE_W)) u_tx_win (
        .clk(clk), .rst_n(rst_n), .spe_valid(tx_spe_valid), .b3_slot(tx_b3_slot),
        .data(tx_data_in), .parity(tx_par), .tracking(tx_track)
    );

    bip_window_track #(.BYTE_W(BYTE_W)) u_rx_win (
        .clk(clk), .rst_n(rst_n), .spe_valid(rx_spe_valid), .b3_slot(rx_b3_slot),
        .data(rx_data), .parity(rx_par), .tracking(rx_track)
    );

    bip_popcount #(.BYTE_W(BYTE_W)) u_pc (
        .bits(rx_data ^ rx_par), .ones(rx_ones)
    );

    assign rx_add = (rx_b3_slot && rx_track) ? rx_ones : '0;

    bip_err_counter #(.CNT_W(CNT_W), .PC_W(PC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .add(rx_add), .rd(cnt_read),
        .count(err_count), .snap(count_snap)
    );

    // transmit insertion stage
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_data_out <= '0;
        else if (tx_b3_slot)
            tx_data_out <= (tx_gen_disable || !tx_track) ? '0 : tx_par;
        else
            tx_data_out <= tx_data_in;
    end
endmodule

// File: rtl/path_bip8_checker.sv
module path_bip8_checker #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_b3_slot,
    input logic [BYTE_W-1:0] tx_data_in,
    input logic              tx_gen_disable,
    input logic [BYTE_W-1:0] tx_data_out,
    input logic              rx_b3_slot,
    input logic              rx_track,
    input logic              cnt_read,
    input logic [CNT_W-1:0]  err_count,
    input logic [CNT_W-1:0]  count_snap
);
    assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tx_b3_slot)) |-> tx_data_out == $past(tx_data_in));

    assert_disable_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_b3_slot) && $past(tx_gen_disable)) |-> tx_data_out == '0);

    assert_no_early_compare_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_b3_slot && !rx_track && !cnt_read) |=> err_count == $past(err_count));

    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_read)) |->
            (int'(err_count) - int'($past(err_count)) <= BYTE_W));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_read)) |-> err_count >= $past(err_count));

    assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_read)) |-> count_snap == $past(err_count));
endmodule

bind path_bip8_unit path_bip8_checker #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_b3_slot(tx_b3_slot), .tx_data_in(tx_data_in),
    .tx_gen_disable(tx_gen_disable), .tx_data_out(tx_data_out),
    .rx_b3_slot(rx_b3_slot), .rx_track(rx_track), .cnt_read(cnt_read),
    .err_count(err_count), .count_snap(count_snap)
);

// File: tb/path_bip8_unit_bench.sv
module path_bip8_unit_bench;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_spe_valid = 0, tx_b3_slot = 0, tx_gen_disable = 0;
    logic rx_spe_valid = 0, rx_b3_slot = 0, cnt_read = 0;
    logic [7:0] tx_data_in = '0, rx_data = '0, tx_data_out;
    logic [CNT_W-1:0] err_count, count_snap;

    always #4 clk = ~clk;

    path_bip8_unit #(.BYTE_W(8), .CNT_W(CNT_W)) u_path_bip8_unit (
        .clk(clk), .rst_n(rst_n), .tx_spe_valid(tx_spe_valid), .tx_b3_slot(tx_b3_slot),
        .tx_data_in(tx_data_in), .tx_gen_disable(tx_gen_disable), .tx_data_out(tx_data_out),
        .rx_spe_valid(rx_spe_valid), .rx_b3_slot(rx_b3_slot), .rx_data(rx_data),
        .cnt_read(cnt_read), .err_count(err_count), .count_snap(count_snap)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    // reference model state
    logic [7:0] m_tx_acc = '0, m_rx_acc = '0;
    bit m_tx_trk = 0, m_rx_trk = 0;
    int m_cnt = 0, m_snap = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: one expected transmit byte per clock
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(tx_data_out), int'(e));
        end
    end

    task automatic step(logic [7:0] td, bit tv, bit ts, bit dis,
                        logic [7:0] rd, bit rv, bit rs, bit rdreq, string ctag);
        int add;
        @(negedge clk);
        tx_data_in = td; tx_spe_valid = tv; tx_b3_slot = ts; tx_gen_disable = dis;
        rx_data = rd; rx_spe_valid = rv; rx_b3_slot = rs; cnt_read = rdreq;
        if (ts) begin
            exp_q.push_back((dis || !m_tx_trk) ? 8'h00 : m_tx_acc);
            tag_q.push_back(dis ? "R5" : (!m_tx_trk ? "R4" : "R3"));
            m_tx_acc = '0; m_tx_trk = 1;
        end else begin
            exp_q.push_back(td);
            tag_q.push_back("R2");
            if (tv) m_tx_acc ^= td;
        end
        add = 0;
        if (rs) begin
            if (m_rx_trk) add = $countones(rd ^ m_rx_acc);
            m_rx_acc = '0; m_rx_trk = 1;
        end else if (rv) m_rx_acc ^= rd;
        if (rdreq) begin
            m_snap = m_cnt;
            m_cnt = (add > CMAX) ? CMAX : add;
        end else begin
            m_cnt = (m_cnt + add > CMAX) ? CMAX : m_cnt + add;
        end
        @(posedge clk);
        #1;
        check(ctag, int'(err_count), m_cnt);
        if (rdreq) check("R8 snapshot", int'(count_snap), m_snap);
    endtask

    // one frame: parity slot carrying model parity ^ mask, then payload bytes
    task automatic frame(int len, int salt, bit dis, logic [7:0] mask, bit rdreq, string ctag);
        step(8'hA5, 1'b1, 1'b1, dis, m_rx_acc ^ mask, 1'b1, 1'b1, rdreq, ctag);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + salt * 11 + 5);
            step(d, (i % 5) != 3, 1'b0, 1'b0, d ^ 8'(salt), (i % 4) != 2, 1'b0, 1'b0, ctag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 tx", int'(tx_data_out), 0);
        check("R1 count", int'(err_count), 0);
        check("R1 snap", int'(count_snap), 0);
        @(negedge clk);
        rst_n = 1'b1;
        frame(20, 1, 0, 8'hFF, 0, "R4 no compare");
        frame(20, 2, 0, 8'h01, 0, "R6");
        frame(17, 3, 0, 8'h00, 0, "R6");
        frame(33, 4, 0, 8'h0F, 0, "R6");
        frame(12, 5, 1, 8'h00, 0, "R5 count");
        frame(15, 6, 0, 8'h03, 1, "R8 count");
        frame(10, 7, 0, 8'hFF, 0, "R6");
        frame(10, 8, 0, 8'hFF, 0, "R7");
        frame(10, 9, 0, 8'h01, 0, "R7");
        step(8'h3C, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8 count");
        frame(8, 10, 0, 8'h80, 0, "R6");
        frame(8, 11, 0, 8'h00, 0, "R6");
        step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R6");
        #2;
        finish_run();
    end
endmodule